// File: doc/BRIEF.md
# Fault Dispatch Escalation Controller

This block chooses the handler vector a processor core dispatches when a fault is reported, and escalates when a new fault lands while a handler is still being entered. A fault request carries a cause code. When no entry is under way, the block issues a one-cycle dispatch strobe with the vector for that cause. The dispatch sequencer then reports that handler entry has finished. If another fault arrives before that report, the pending dispatch is dropped and the fixed double-fault vector is issued instead. If a fault also arrives while the double-fault handler is being entered, dispatching stops. The block then holds a shutdown indication and a reset request to the platform until a synchronous reset arrives.

The block keeps no record of being inside a handler once entry has finished. A fault raised by handler code after entry is an ordinary first fault, even when its cause matches the running handler. Privilege level plays no part in the decision. Instruction fetch, state stacking and memory access are represented only by the fault and entry-complete inputs.

Top module: `exc_escalate_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes to idle, and in the following cycle `disp_start`, `shutdown` and `plat_rst_req` are all low.
- R2: A fault sampled while idle produces `disp_start` high in the next cycle, with `disp_vector` equal to `VEC_BASE` plus the cause code (default base 0, so the vector is the 3-bit cause zero-extended to 4 bits).
- R3: A fault sampled while a normal handler entry is pending, with entry-complete low, produces `disp_start` in the next cycle with `disp_vector` equal to `DF_VEC` (default 8).
- R4: A fault sampled while the double-fault entry is pending, with entry-complete low, produces no dispatch. In the next cycle `shutdown` and `plat_rst_req` are high.
- R5: After entry-complete has been sampled, a later fault dispatches its own cause vector, never `DF_VEC`.
- R6: A fault and entry-complete sampled in the same cycle during any pending entry count as a fresh first fault: the next cycle dispatches the cause vector, even during double-fault entry.
- R7: A fault whose cause equals that of the handler just entered restarts that handler with the same cause vector.
- R8: `disp_start` is high only in the cycle after a sampled fault. A single accepted fault gives a pulse exactly one cycle long, and an idle block with no fault never dispatches.
- R9: In shutdown, fault requests and entry-complete are ignored: no dispatch occurs and `shutdown` and `plat_rst_req` stay high until reset.
- R10: A reset taken from shutdown returns the block to idle, and the next fault receives its normal cause vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_req | input | 1 | Fault request strobe, sampled on the clock edge |
| fault_cause | input | CAUSE_W (3) | Cause code of the fault |
| entry_done | input | 1 | Handler entry complete strobe from the dispatch sequencer |
| disp_start | output | 1 | One-cycle dispatch strobe |
| disp_vector | output | VEC_W (4) | Vector index, valid while disp_start is high |
| shutdown | output | 1 | Held high while in the shutdown state |
| plat_rst_req | output | 1 | Reset request to the platform, high during shutdown |

## Verification
The hardest case to reach from the ports is the boundary between double-fault entry and completion. A fault arriving in the same cycle as entry-complete must restart as a first fault and not cause shutdown. One cycle later, with no completion, the same fault must cause shutdown. The stimulus first creates a double-fault entry with two faults on consecutive cycles. It then either raises fault and entry-complete together, or raises the fault alone, and it repeats this with causes that match the handler just entered. Shutdown is then hammered with faults and completion strobes before a reset is applied.

// File: rtl/exc_esc_pkg.sv
package exc_esc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ENTER    = 2'd1,
        ST_ENTER_DF = 2'd2,
        ST_SHUTDOWN = 2'd3
    } esc_state_e;

    typedef enum logic [1:0] {
        DSP_NONE   = 2'd0,
        DSP_NORMAL = 2'd1,
        DSP_DOUBLE = 2'd2
    } dispatch_kind_e;

    function automatic logic entry_pending(input esc_state_e s);
        return (s == ST_ENTER) || (s == ST_ENTER_DF);
    endfunction

endpackage

// File: rtl/exc_cause_map.sv
module exc_cause_map #(
    parameter int CAUSE_W  = 3,
    parameter int VEC_W    = 4,
    parameter int VEC_BASE = 0
) (
    input  logic [CAUSE_W-1:0] cause,
    output logic [VEC_W-1:0]   vector
);
    localparam logic [VEC_W-1:0] BASE_V = VEC_W'(VEC_BASE);

    always_comb begin
        vector = BASE_V + VEC_W'(cause);
    end
endmodule

// File: rtl/exc_esc_fsm.sv
module exc_esc_fsm
    import exc_esc_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           fault_req,
    input  logic           entry_done,
    output esc_state_e     state,
    output dispatch_kind_e kind
);
    esc_state_e state_n;

    always_comb begin
        state_n = state;
        kind    = DSP_NONE;
        unique case (state)
            ST_IDLE: begin
                if (fault_req) begin
                    state_n = ST_ENTER;
                    kind    = DSP_NORMAL;
                end
            end
            ST_ENTER, ST_ENTER_DF: begin
                if (entry_done) begin
                    // Completion wins: a coincident fault is a fresh first fault.
                    if (fault_req) begin
                        state_n = ST_ENTER;
                        kind    = DSP_NORMAL;
                    end else begin
                        state_n = ST_IDLE;
                    end
                end else if (fault_req) begin
                    if (state == ST_ENTER) begin
                        state_n = ST_ENTER_DF;
                        kind    = DSP_DOUBLE;
                    end else begin
                        state_n = ST_SHUTDOWN;
                    end
                end
            end
            ST_SHUTDOWN: state_n = ST_SHUTDOWN;
            default:     state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_n;
    end

    // R9: shutdown is sticky until reset
    a_r9_sticky_shutdown: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHUTDOWN) |=> (state == ST_SHUTDOWN));

    // R5: completion without a fault always returns to idle
    a_r5_done_clears: assert property (@(posedge clk) disable iff (rst)
        (entry_pending(state) && entry_done && !fault_req) |=> (state == ST_IDLE));
endmodule

// File: rtl/exc_disp_out.sv
module exc_disp_out
    import exc_esc_pkg::*;
#(
    parameter int VEC_W  = 4,
    parameter int DF_VEC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  dispatch_kind_e   kind,
    input  logic [VEC_W-1:0] cause_vec,
    input  esc_state_e       state,
    output logic             disp_start,
    output logic [VEC_W-1:0] disp_vector,
    output logic             shutdown,
    output logic             plat_rst_req
);
    localparam logic [VEC_W-1:0] DF_V = VEC_W'(DF_VEC);

    always_ff @(posedge clk) begin
        if (rst) begin
            disp_start  <= 1'b0;
            disp_vector <= '0;
        end else begin
            disp_start <= (kind != DSP_NONE);
            if (kind == DSP_DOUBLE)      disp_vector <= DF_V;
            else if (kind == DSP_NORMAL) disp_vector <= cause_vec;
        end
    end

    always_comb begin
        shutdown     = (state == ST_SHUTDOWN);
        plat_rst_req = (state == ST_SHUTDOWN);
    end
endmodule

// File: rtl/exc_escalate_ctrl.sv
module exc_escalate_ctrl
    import exc_esc_pkg::*;
#(
    parameter int CAUSE_W  = 3,
    parameter int VEC_W    = 4,
    parameter int VEC_BASE = 0,
    parameter int DF_VEC   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fault_req,
    input  logic [CAUSE_W-1:0] fault_cause,
    input  logic               entry_done,
    output logic               disp_start,
    output logic [VEC_W-1:0]   disp_vector,
    output logic               shutdown,
    output logic               plat_rst_req
);
    localparam logic [VEC_W-1:0] DF_V = VEC_W'(DF_VEC);

    esc_state_e       state;
    dispatch_kind_e   kind;
    logic [VEC_W-1:0] cause_vec;

    exc_cause_map #(.CAUSE_W(CAUSE_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_map (
        .cause  (fault_cause),
        .vector (cause_vec)
    );

    exc_esc_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .fault_req  (fault_req),
        .entry_done (entry_done),
        .state      (state),
        .kind       (kind)
    );

    exc_disp_out #(.VEC_W(VEC_W), .DF_VEC(DF_VEC)) u_out (
        .clk          (clk),
        .rst          (rst),
        .kind         (kind),
        .cause_vec    (cause_vec),
        .state        (state),
        .disp_start   (disp_start),
        .disp_vector  (disp_vector),
        .shutdown     (shutdown),
        .plat_rst_req (plat_rst_req)
    );

    // R2
    a_r2_idle_dispatch: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && fault_req) |=> (disp_start && disp_vector == $past(cause_vec)));
    // R3
    a_r3_double_vector: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ENTER && fault_req && !entry_done) |=> (disp_start && disp_vector == DF_V));
    // R4
    a_r4_shutdown_entry: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ENTER_DF && fault_req && !entry_done) |=> (shutdown && plat_rst_req && !disp_start));
    // R6
    a_r6_done_first: assert property (@(posedge clk) disable iff (rst)
        (entry_pending(state) && fault_req && entry_done) |=> (disp_start && disp_vector == $past(cause_vec)));
    // R8
    a_r8_start_needs_fault: assert property (@(posedge clk) disable iff (rst)
        disp_start |-> $past(fault_req));
    // R9
    a_r9_no_dispatch_in_shutdown: assert property (@(posedge clk) disable iff (rst)
        shutdown |-> !disp_start);
endmodule

// File: tb/exc_escalate_ctrl_bench.sv
module exc_escalate_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fault_req = 1'b0;
    logic [2:0] fault_cause = '0;
    logic       entry_done = 1'b0;
    logic       disp_start, shutdown, plat_rst_req;
    logic [3:0] disp_vector;

    int checks = 0;
    int failures = 0;
    bit done_flag = 0;

    typedef struct {
        bit         start;
        logic [3:0] vec;
        bit         sd;
        string      req;
    } exp_t;
    exp_t q[$];

    // bench model: 0 idle, 1 entering, 2 entering double, 3 shutdown
    int m = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_escalate_ctrl u_exc_escalate_ctrl (
        .clk(clk), .rst(rst), .fault_req(fault_req), .fault_cause(fault_cause),
        .entry_done(entry_done), .disp_start(disp_start), .disp_vector(disp_vector),
        .shutdown(shutdown), .plat_rst_req(plat_rst_req)
    );

    task automatic step(input bit r, input bit f, input logic [2:0] c, input bit d, input string req);
        exp_t e;
        @(negedge clk);
        #1;
        rst = r; fault_req = f; fault_cause = c; entry_done = d;
        e.start = 0; e.vec = 'x; e.req = req;
        if (r) m = 0;
        else if (m == 3) m = 3;
        else if (m == 0 || d) begin
            if (f) begin m = 1; e.start = 1; e.vec = {1'b0, c}; end
            else m = 0;
        end else if (f) begin
            if (m == 1) begin m = 2; e.start = 1; e.vec = 4'd8; end
            else m = 3;
        end
        e.sd = (m == 3);
        q.push_back(e);
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (disp_start !== e.start || shutdown !== e.sd || plat_rst_req !== e.sd ||
                (e.start && disp_vector !== e.vec)) begin
                failures++;
                $display("FAIL %s: got start=%0b vec=%0d sd=%0b rreq=%0b, expected start=%0b vec=%0d sd=%0b",
                         e.req, disp_start, disp_vector, shutdown, plat_rst_req, e.start, e.vec, e.sd);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done_flag) begin
            failures++;
            checks++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step(1, 0, 0, 0, "R1");
        step(1, 1, 3, 0, "R1");
        step(0, 0, 0, 0, "R8");
        step(0, 0, 0, 0, "R8");
        step(0, 1, 3, 0, "R2");
        step(0, 0, 0, 0, "R8");
        step(0, 0, 0, 1, "R5");
        step(0, 1, 5, 0, "R5");
        step(0, 1, 2, 0, "R3");
        step(0, 0, 0, 1, "R5");
        step(0, 1, 6, 0, "R2");
        step(0, 1, 6, 1, "R6");
        step(0, 0, 0, 1, "R5");
        step(0, 1, 6, 0, "R7");
        step(0, 0, 0, 1, "R7");
        step(0, 1, 6, 0, "R7");
        step(0, 1, 0, 0, "R3");
        step(0, 1, 4, 1, "R6");
        step(0, 1, 1, 0, "R3");
        step(0, 0, 0, 0, "R8");
        step(0, 1, 7, 0, "R4");
        step(0, 1, 2, 0, "R9");
        step(0, 1, 3, 1, "R9");
        step(0, 0, 0, 1, "R9");
        step(0, 0, 0, 0, "R9");
        step(1, 0, 0, 0, "R10");
        step(0, 1, 7, 0, "R10");
        step(0, 0, 0, 1, "R5");
        step(0, 0, 0, 0, "R8");
        for (int i = 0; i < 8; i++) begin
            step(0, 1, 3'(i), 0, "R2");
            step(0, 1, 3'(i), 1, "R6");
            step(0, 0, 0, 1, "R5");
        end
        step(0, 0, 0, 0, "R8");
        @(negedge clk);
        @(negedge clk);
        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule